// File: doc/BRIEF.md
# Static LCD Segment Driver

This block drives a static (non-multiplexed) liquid-crystal display that shows three and a half digits. It takes a packed BCD reading of three full digits, a flag for the leading half digit, a sign bit and an overrange flag. A one-cycle strobe tells it when a new reading is present. The block decodes each full digit into seven segment on-bits and holds the whole pattern until the next strobe.

The block divides the oscillator clock down to a square-wave backplane. Every segment pin carries that same square wave. A segment that is lit gets the inverted wave and a dark one gets the wave unchanged, so the average voltage across each segment is zero. In logic terms, each segment pin is its on-bit XOR the backplane.

The leading half digit can only show a "1" and uses one pin. The sign indicator also uses one pin and is lit for a negative reading.

Top module: `lcd_static_driver`

## Requirements
- R1: After reset is released, `bp_out` is low. It rises after DIV/2 clock cycles and then toggles every DIV/2 cycles, giving a 50% duty square wave with a period of DIV cycles. The default DIV is 800.
- R2: A segment that is off drives its pin equal to `bp_out`, in phase with the backplane.
- R3: A segment that is on drives its pin equal to the inverse of `bp_out`, in antiphase with the backplane.
- R4: Each digit uses seven bits: bit 0 is segment a and bit 6 is segment g. Digit 0 (units) sits at `seg_out[6:0]` and takes its code from `rd_bcd[3:0]`. The on-patterns for codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R5: A digit code from 10 to 15 lights no segment of that digit.
- R6: `half_out` is lit when the captured `rd_half` is 1.
- R7: `sign_out` is lit when the captured `rd_neg` is 1 and dark otherwise.
- R8: A strobe with `rd_ovr` set blanks all three full digits and lights the half digit. The sign still follows `rd_neg`.
- R9: The pattern changes only on a clock edge where `rd_valid` is 1. Input changes without the strobe have no effect on any pin's phase.
- R10: After reset every segment, the half digit and the sign are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | One-cycle strobe: capture the reading |
| rd_bcd | input | 12 | Three BCD digits, units in the low nibble |
| rd_half | input | 1 | Leading "1" requested |
| rd_neg | input | 1 | Reading is negative |
| rd_ovr | input | 1 | Reading is overrange |
| bp_out | output | 1 | Backplane square wave |
| seg_out | output | 21 | Segment pins a..g for each full digit |
| half_out | output | 1 | Half-digit pin, which lights both segments of the "1" |
| sign_out | output | 1 | Minus-sign pin |

## Verification
Suppose the held pattern is corrupted, for example by a wrong decode entry, a lost strobe or a missed overrange blank. The affected pin then shows the wrong phase against the backplane from the clock edge that captured the reading onward. It stays wrong until the next strobe, so a check right after the strobe sees it. A fault in the divider count moves the backplane edges away from the DIV/2 spacing. This shows up at the first toggle after reset. Because the same backplane feeds every pin, a backplane fault never shows up as a phase error on any single segment. The bench therefore checks the backplane timing on its own and checks each segment only relative to the backplane.

// File: rtl/lcd_pkg.sv
// Shared constants and the BCD-to-seven-segment decode for the LCD driver.
// Assumes segment order a..g in bits 0..6.
package lcd_pkg;
    localparam int SEG_W = 7;

    // Decode one BCD code to on-bits; codes 10..15 give a blank digit.
    function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [3:0] code);
        logic [SEG_W-1:0] s;
        case (code)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/lcd_bp_gen.sv
// Backplane generator: divides clk by DIV to make a 50% duty square wave.
// Assumes DIV is even and at least 2. The output is low from reset.
module lcd_bp_gen #(
    parameter int DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Count half periods and flip the backplane at each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_bp_flips_at_terminal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(HALF - 1)) |=> (bp != $past(bp)));

    assert_bp_steady_midway_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CW'(HALF - 1)) |=> $stable(bp));

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(HALF));
endmodule

// File: rtl/lcd_frame_latch.sv
// Frame latch: on each result strobe, decodes the digits and holds the on-bits
// for the whole display until the next strobe. Overrange blanks the full digits
// and forces the leading "1". Assumes rd_valid is a single-cycle pulse.
module lcd_frame_latch
    import lcd_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_valid,
    input  logic [4*NDIG-1:0]     rd_bcd,
    input  logic                  rd_half,
    input  logic                  rd_neg,
    input  logic                  rd_ovr,
    output logic [SEG_W*NDIG-1:0] dig_on,
    output logic                  half_on,
    output logic                  sign_on
);
    logic [SEG_W*NDIG-1:0] dig_next;

    // One decoder per full digit, blanked on overrange.
    for (genvar d = 0; d < NDIG; d++) begin : g_dec
        always_comb begin
            dig_next[SEG_W*d +: SEG_W] = rd_ovr ? '0 : bcd_to_seg(rd_bcd[4*d +: 4]);
        end
    end

    // Capture the decoded frame on the strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_on  <= '0;
            half_on <= 1'b0;
            sign_on <= 1'b0;
        end else if (rd_valid) begin
            dig_on  <= dig_next;
            half_on <= rd_half | rd_ovr;
            sign_on <= rd_neg;
        end
    end

    assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ($stable(dig_on) && $stable(half_on) && $stable(sign_on)));

    assert_ovr_blanks_digits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ovr) |=> (dig_on == '0 && half_on));

    assert_sign_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (sign_on == $past(rd_neg)));
endmodule

// File: rtl/lcd_ac_drive.sv
// AC drive stage: turns each on-bit into an in-phase (off) or antiphase (on)
// copy of the backplane. Purely combinational, fed from registers.
module lcd_ac_drive #(
    parameter int W = 23
) (
    input  logic         bp,
    input  logic [W-1:0] on_bits,
    output logic [W-1:0] pins
);
    // Invert the backplane for every lit segment.
    always_comb begin
        pins = on_bits ^ {W{bp}};
    end
endmodule

// File: rtl/lcd_static_driver.sv
// Top of the static LCD driver: backplane generator, frame latch and AC drive.
// Assumes a single clock domain and a synchronous active-low reset.
module lcd_static_driver
    import lcd_pkg::*;
#(
    parameter int DIV  = 800,
    parameter int NDIG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_valid,
    input  logic [4*NDIG-1:0]     rd_bcd,
    input  logic                  rd_half,
    input  logic                  rd_neg,
    input  logic                  rd_ovr,
    output logic                  bp_out,
    output logic [SEG_W*NDIG-1:0] seg_out,
    output logic                  half_out,
    output logic                  sign_out
);
    localparam int DW = SEG_W * NDIG;
    localparam int PW = DW + 2;

    logic          bp;
    logic [DW-1:0] dig_on;
    logic          half_on;
    logic          sign_on;
    logic [PW-1:0] pins;

    lcd_bp_gen #(.DIV(DIV)) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .bp    (bp)
    );

    lcd_frame_latch #(.NDIG(NDIG)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_bcd   (rd_bcd),
        .rd_half  (rd_half),
        .rd_neg   (rd_neg),
        .rd_ovr   (rd_ovr),
        .dig_on   (dig_on),
        .half_on  (half_on),
        .sign_on  (sign_on)
    );

    lcd_ac_drive #(.W(PW)) u_drive (
        .bp      (bp),
        .on_bits ({sign_on, half_on, dig_on}),
        .pins    (pins)
    );

    // Split the driven pins back onto the named outputs.
    always_comb begin
        bp_out   = bp;
        seg_out  = pins[DW-1:0];
        half_out = pins[DW];
        sign_out = pins[DW+1];
    end

    assert_blank_after_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (seg_out == {DW{bp_out}} && half_out == bp_out && sign_out == bp_out));
endmodule

// File: tb/sim_lcd_static_driver.sv
// Scoreboard bench: the driver task queues expected on-bit frames and the
// monitor pops each one and compares the pins against the observed backplane.
module sim_lcd_static_driver;
    localparam int DIV  = 800;
    localparam int HALF = DIV / 2;
    localparam int NDIG = 3;
    localparam int W    = 7 * NDIG + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_valid = 1'b0;
    logic [4*NDIG-1:0] rd_bcd = '0;
    logic rd_half = 1'b0, rd_neg = 1'b0, rd_ovr = 1'b0;
    logic bp_out, half_out, sign_out;
    logic [7*NDIG-1:0] seg_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] cur_exp = '0;

    always #2.5 clk = ~clk;

    lcd_static_driver #(.DIV(DIV), .NDIG(NDIG)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_bcd(rd_bcd),
        .rd_half(rd_half), .rd_neg(rd_neg), .rd_ovr(rd_ovr),
        .bp_out(bp_out), .seg_out(seg_out), .half_out(half_out), .sign_out(sign_out)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [11:0] bcd, input logic h,
                                           input logic n, input logic o);
        logic [7*NDIG-1:0] d;
        for (int i = 0; i < NDIG; i++) d[7*i +: 7] = o ? 7'h00 : ref_seg(bcd[4*i +: 4]);
        return {n, h | o, d};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: strobe a reading, then queue the expected frame in both backplane phases.
    task automatic apply(input string tag, input logic [11:0] bcd, input logic h,
                         input logic n, input logic o);
        @(negedge clk);
        rd_bcd = bcd; rd_half = h; rd_neg = n; rd_ovr = o; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        cur_exp = model(bcd, h, n, o);
        exp_q.push_back(cur_exp); tag_q.push_back(tag);
        repeat (HALF) @(negedge clk);
        exp_q.push_back(cur_exp); tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: pop each queued frame and compare pins with on-bits XOR backplane.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " (R2/R3 phase)"}, {sign_out, half_out, seg_out}, e ^ {W{bp_out}});
            end
        end
    end

    // Backplane timing: first rise and the spacing of the next edges (R1).
    initial begin
        int n;
        logic last;
        @(posedge rst_n);
        @(negedge clk);
        #1;
        checks++;
        if (bp_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 bp after reset actual=%b expected=0", bp_out);
        end
        n = 1;
        while (bp_out !== 1'b1 && n < DIV) begin
            @(negedge clk); #1; n++;
        end
        checks++;
        if (n != HALF) begin
            errors++;
            $display("FAIL R1 first rise actual=%0d expected=%0d", n, HALF);
        end
        for (int k = 0; k < 4; k++) begin
            last = bp_out;
            n = 0;
            do begin
                @(negedge clk); #1; n++;
            end while (bp_out === last && n < DIV);
            checks++;
            if (n != HALF) begin
                errors++;
                $display("FAIL R1 half period actual=%0d expected=%0d", n, HALF);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: all pins off right after reset
        check("R10 reset pattern", {sign_out, half_out, seg_out}, {W{bp_out}});
        apply("R4 digits 1,2,3",        12'h123, 1'b0, 1'b0, 1'b0);
        apply("R4 digits 4,5,6",        12'h456, 1'b0, 1'b0, 1'b0);
        apply("R4 digits 7,8,9",        12'h789, 1'b0, 1'b0, 1'b0);
        apply("R4 R6 R7 digit 0 neg half", 12'h000, 1'b1, 1'b1, 1'b0);
        apply("R5 codes A,C,F blank",   12'hFCA, 1'b0, 1'b0, 1'b0);
        apply("R5 mixed code E",        12'h9E1, 1'b1, 1'b0, 1'b0);
        apply("R8 overrange positive",  12'h888, 1'b0, 1'b0, 1'b1);
        apply("R8 R7 overrange negative", 12'h555, 1'b0, 1'b1, 1'b1);
        apply("R7 sign clears",         12'h321, 1'b1, 1'b0, 1'b0);
        // R9: change inputs with no strobe; the held pattern must stay
        @(negedge clk);
        rd_bcd = 12'h888; rd_half = 1'b0; rd_neg = 1'b1; rd_ovr = 1'b1;
        repeat (3) @(negedge clk);
        exp_q.push_back(cur_exp); tag_q.push_back("R9 hold without strobe");
        repeat (HALF) @(negedge clk);
        exp_q.push_back(cur_exp); tag_q.push_back("R9 hold other phase");
        repeat (2) @(negedge clk);
        wait (exp_q.size() == 0);
        repeat (DIV * 3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule